// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a programmed number of seconds and raises an alarm when the count runs out. Software writes a load value, which is a number of seconds. It then sets the run control. From that point the remaining count drops by one on every seconds strobe. When the remaining count reaches zero, a sticky pending flag is set and the count stays at zero.

Two outputs follow the pending flag. The interrupt output is high while the flag is set and the interrupt mask bit is set. The wake output is high while the flag is set and the wake configuration bit is set. Software clears the flag by writing a one to it. Software can read back all control registers and the live remaining count through a simple register port.

The register port uses word addresses: 0 is the load value, 1 is the remaining count (read-only), 2 is run, 3 is the interrupt mask, 4 is status, and 5 is the wake configuration. Each single-bit control is bit 0 of its word. Writes take effect at the clock edge at which `wr_en` is sampled high. Reads are combinational from the addressed state.

Top module: `countdown_alarm`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `wake` are low.
- R2: A write to address 0 stores the load value and also copies it into the remaining count, both visible from the next cycle. This happens whether or not the alarm is running.
- R3: While run (address 2, bit 0) is 1, each cycle with `sec_tick` high lowers a nonzero remaining count by exactly one. The count holds when `sec_tick` is low or run is 0.
- R4: The tick that takes the remaining count from 1 to 0 sets pending (address 4, bit 0) at the same edge. Further ticks leave the count at 0.
- R5: A load of 0 leaves the remaining count at 0 and pending clear, however many ticks follow.
- R6: Writing run from 0 to 1 reloads the remaining count from the stored load value. Clearing run freezes the count.
- R7: `irq` equals pending AND the interrupt mask (address 3, bit 0).
- R8: `wake` equals pending AND the wake configuration (address 5, bit 0).
- R9: Writing address 4 with bit 0 set clears pending. Writing it with bit 0 clear leaves pending unchanged.
- R10: When expiry and a clearing write to address 4 fall in the same cycle, pending ends up set.
- R11: Writes to address 1 and to unmapped addresses change no state. Reads of unmapped addresses (6, 7) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | CNT_W | Register read data, combinational |
| irq | output | 1 | Interrupt: pending and mask both set |
| wake | output | 1 | Wake request: pending and wake config both set |

## Verification
Every state change lands on the first clock edge after its stimulus. This covers register writes, reloads, decrements, pending set and pending clear. Because `rd_data`, `irq` and `wake` are combinational from that state, each result is due one cycle after the stimulus is presented. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then samples on the following falling edge, so each check looks at the cycle in which its result is due and never at an edge. The sweep runs each load value from 1 to 6 against all four mask and wake combinations. It checks the remaining count after every tick, and it checks that pending appears on exactly the final tick.

// File: rtl/countdown_alarm.sv
module countdown_alarm #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              wake
);

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_REMAIN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RUN    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WAKE   = ADDR_W'(5);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [CNT_W-1:0] load_q, remain_q;
  logic run_q, irq_en_q, pend_q, wake_cfg_q;

  wire wr_load  = wr_en && (wr_addr == A_LOAD);
  wire wr_run   = wr_en && (wr_addr == A_RUN);
  wire wr_irqen = wr_en && (wr_addr == A_IRQEN);
  wire wr_stat  = wr_en && (wr_addr == A_STATUS);
  wire wr_wake  = wr_en && (wr_addr == A_WAKE);

  wire run_rise = wr_run && wr_data[0] && !run_q;
  wire reload   = wr_load || run_rise;
  wire counting = run_q && sec_tick && (remain_q != '0);
  wire expire   = counting && (remain_q == ONE) && !reload;
  wire clr_pend = wr_stat && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q     <= '0;
      remain_q   <= '0;
      run_q      <= 1'b0;
      irq_en_q   <= 1'b0;
      pend_q     <= 1'b0;
      wake_cfg_q <= 1'b0;
    end else begin
      if (wr_load)  load_q     <= wr_data;
      if (wr_run)   run_q      <= wr_data[0];
      if (wr_irqen) irq_en_q   <= wr_data[0];
      if (wr_wake)  wake_cfg_q <= wr_data[0];

      if (wr_load)       remain_q <= wr_data;
      else if (run_rise) remain_q <= load_q;
      else if (counting) remain_q <= remain_q - ONE;

      if (expire)        pend_q <= 1'b1;
      else if (clr_pend) pend_q <= 1'b0;
    end
  end

  assign irq  = pend_q && irq_en_q;
  assign wake = pend_q && wake_cfg_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_LOAD:   rd_data = load_q;
      A_REMAIN: rd_data = remain_q;
      A_RUN:    rd_data[0] = run_q;
      A_IRQEN:  rd_data[0] = irq_en_q;
      A_STATUS: rd_data[0] = pend_q;
      A_WAKE:   rd_data[0] = wake_cfg_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/countdown_alarm_chk.sv
module countdown_alarm_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bit0,
  input logic [CNT_W-1:0]  remain_q,
  input logic              run_q,
  input logic              pend_q,
  input logic              irq_en_q,
  input logic              wake_cfg_q,
  input logic              irq,
  input logic              wake
);

  wire [CNT_W-1:0] one = CNT_W'(1);
  wire last_tick = run_q && sec_tick && (remain_q == one) && !wr_en;
  wire clr_wr    = wr_en && (wr_addr == ADDR_W'(4)) && wr_bit0;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sec_tick && (remain_q > one) && !wr_en) |=> (remain_q == $past(remain_q) - one));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> $stable(remain_q));

  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> (pend_q && (remain_q == '0)));

  assert_zero_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((remain_q == '0) && !wr_en) |=> ((remain_q == '0) && (pend_q || !$rose(pend_q))));

  assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q && irq_en_q));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (pend_q && wake_cfg_q));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(run_q && sec_tick && (remain_q == one))) |=> !pend_q);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && run_q && sec_tick && (remain_q == one)) |=> pend_q);

endmodule

bind countdown_alarm countdown_alarm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .remain_q(remain_q),
  .run_q(run_q), .pend_q(pend_q), .irq_en_q(irq_en_q),
  .wake_cfg_q(wake_cfg_q), .irq(irq), .wake(wake)
);

// File: tb/sim_countdown_alarm.sv
module sim_countdown_alarm;
  localparam int CW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic irq, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  countdown_alarm #(.CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit we, input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    sec_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic tick();
    cyc(1'b1, 1'b0, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [CW-1:0] e, input string req);
    logic [CW-1:0] v;
    rd(a, v);
    check(v == e, req, longint'(v), longint'(e));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) expect_reg(AW'(a), '0, "R1");
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(wake == 1'b0, "R1 wake", wake, 0);

    // R3 R4 R7 R8 sweep over loads and output configs
    for (int n = 1; n <= 6; n++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        wr(3'd2, 0);
        wr(3'd4, 1);
        wr(3'd3, CW'(cfg & 1));
        wr(3'd5, CW'(cfg >> 1));
        wr(3'd0, CW'(n));
        expect_reg(3'd1, CW'(n), "R2");
        wr(3'd2, 1);
        expect_reg(3'd1, CW'(n), "R6");
        for (int k = 1; k <= n; k++) begin
          expect_reg(3'd4, 0, "R4 early");
          cyc(1'b0, 1'b0, '0, '0);
          expect_reg(3'd1, CW'(n - k + 1), "R3 hold");
          tick();
          expect_reg(3'd1, CW'(n - k), "R3");
        end
        expect_reg(3'd4, 1, "R4");
        check(irq == bit'(cfg & 1), "R7", irq, cfg & 1);
        check(wake == bit'(cfg >> 1), "R8", wake, cfg >> 1);
        tick();
        expect_reg(3'd1, 0, "R4 stays");
      end
    end

    // R9: zero in bit0 keeps pending, one clears it
    wr(3'd4, 32'hFFFF_FFFE);
    expect_reg(3'd4, 1, "R9 keep");
    wr(3'd4, 1);
    expect_reg(3'd4, 0, "R9 clear");
    check(irq == 1'b0 && wake == 1'b0, "R9 outputs", {irq, wake}, 0);

    // R6: pause freezes, re-enable reloads
    wr(3'd2, 0);
    wr(3'd0, 5);
    wr(3'd2, 1);
    tick(); tick();
    expect_reg(3'd1, 3, "R6 run");
    wr(3'd2, 0);
    tick();
    expect_reg(3'd1, 3, "R6 freeze");
    wr(3'd2, 1);
    expect_reg(3'd1, 5, "R6 reload");

    // R2: load while running replaces remaining count
    tick();
    wr(3'd0, 32'hDEAD_BEEF);
    expect_reg(3'd1, 32'hDEAD_BEEF, "R2 running");
    expect_reg(3'd0, 32'hDEAD_BEEF, "R2 load");
    tick();
    expect_reg(3'd1, 32'hDEAD_BEEE, "R3 wide");

    // R5: load of zero
    wr(3'd0, 0);
    for (int i = 0; i < 4; i++) tick();
    expect_reg(3'd1, 0, "R5 count");
    expect_reg(3'd4, 0, "R5 pending");

    // R10: expiry and clear in the same cycle
    wr(3'd0, 1);
    cyc(1'b1, 1'b1, 3'd4, 1);
    expect_reg(3'd4, 1, "R10");
    expect_reg(3'd1, 0, "R10 count");

    // R11: writes to read-only and unmapped addresses ignored
    wr(3'd4, 1);
    wr(3'd0, 9);
    wr(3'd1, 2);
    expect_reg(3'd1, 9, "R11 ro");
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    expect_reg(3'd6, 0, "R11 read6");
    expect_reg(3'd7, 0, "R11 read7");
    expect_reg(3'd0, 9, "R11 load kept");
    expect_reg(3'd4, 0, "R11 pending kept");

    finish_up();
  end
endmodule